// File: doc/BRIEF.md
# Dual-Rail Fault Indication Output Generator

This block drives a two-pin external fault signal from the state of a safety controller. A healthy system is shown by a complementary pair of pin values that must keep alternating, so a stuck or dead output is itself visible as an error. A detected fault is shown by an equal pair that stops moving. Reset and self-test float both pins. An external monitor oversamples the pair and treats any loss of alternation as a failure.

The alternation rate comes from the slow oscillator clock. A fixed prescaler, `PRE_DIV` (1024 by default), divides it first. A programmable factor then divides it again, and a factor of 18 is the usual setting. The configuration state has two behaviours, chosen by a mode input. In labelling mode the pins float while configuration lasts. In transparency mode the configuration state cannot be told apart from normal operation. A fault can only be left towards normal operation, never straight into configuration.

There is no data stream in or out of the block. Every pin is a plain level control or status pin, so no handshake or back-pressure applies. All outputs follow the inputs after one clock edge.

Top module: `dual_rail_fault_out`

## Requirements
- R1: Once reset is released with no fault, no configuration request and no self-test, both enables are 1 from the first edge on. The pair starts at `rail_val`=2'b10 and then alternates between 2'b10 and 2'b01.
- R2: Each value of the alternating pair lasts exactly `PRE_DIV` x `div_factor` clock cycles.
- R3: A `div_factor` of 0 gives the same half-period as a factor of 1.
- R4: One edge after `in_fault` rises, both pins are enabled and show 2'b00. If `fault_code_hi` was 1 at entry, they show 2'b11 instead. The code is captured when the fault is entered and stays static for as long as the fault lasts, even if `fault_code_hi` changes.
- R5: On the first edge after `in_fault` falls, the pair restarts at 2'b10. Both divider stages restart at the same moment, so the first change comes one full half-period later.
- R6: While `rst_n` is low, both enables are 0 at once, without waiting for a clock edge.
- R7: One edge after `self_test` is high, both enables are 0, even if a fault is present. When `self_test` falls, the pair restarts at 2'b10 as in R5.
- R8: With `label_mode`=0, a configuration request (`cfg_state`=1) leaves the pins driven. The alternation carries on with no restart.
- R9: With `label_mode`=1, both enables are 0 one edge after a configuration request. The dividers keep counting, so after the request ends the alternation resumes in the phase it would have had anyway.
- R10: When a fault ends while `cfg_state` is still 1, the block spends exactly one cycle in normal operation, enabled and showing 2'b10. Only after that does it enter configuration.
- R11: A fault takes priority over a configuration request. A fault raised during configuration shows the fault code one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_fault | input | 1 | Controller is in its faulty state |
| cfg_state | input | 1 | Controller is in its configuration state |
| self_test | input | 1 | Self-test is running |
| label_mode | input | 1 | 1: configuration floats the pins; 0: configuration looks like normal |
| fault_code_hi | input | 1 | 1: fault code 2'b11; 0: fault code 2'b00 |
| div_factor | input | FACT_W | Programmable divide factor applied after the fixed prescaler |
| rail_val | output | 2 | Values driven on the two pins |
| rail_oe | output | 2 | Per-pin output enable; 0 floats the pin |

## Verification
A wrong mode register shows up one edge later as the wrong enable pattern or the wrong code. An example is a fault that slips straight into configuration, which would float the pins in the cycle where they should show 2'b10. A divider that is off by one, or that fails to restart after a fault or self-test, first shows at the first value change: it moves the flip by whole cycles, so the comparison at every cycle catches it within a single half-period. A phase that restarts wrongly during configuration only shows once configuration ends, so the bench checks the alternation after both configuration modes.

// File: rtl/rail_pkg.sv
package rail_pkg;
  typedef enum logic [1:0] {
    RM_OFF   = 2'd0,
    RM_RUN   = 2'd1,
    RM_FAULT = 2'd2,
    RM_CFG   = 2'd3
  } rail_mode_e;

  localparam int unsigned RAIL_PINS = 2;
endpackage

// File: rtl/rail_prescale.sv
module rail_prescale #(
  parameter int unsigned PRE_DIV = 1024,
  parameter int unsigned FW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [FW-1:0] factor,
  output logic          tick
);
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [FW-1:0] fac_q;
  logic [FW-1:0] fac_eff;
  logic          pre_tick;
  logic          fac_wrap;

  // zero factor behaves as one so the divider never stalls
  assign fac_eff  = (factor == '0) ? FW'(1) : factor;
  assign pre_tick = (pre_q == PRE_LAST);
  assign fac_wrap = (fac_q >= fac_eff - FW'(1));
  assign tick     = pre_tick && fac_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      fac_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
      fac_q <= '0;
    end else begin
      pre_q <= pre_tick ? '0 : pre_q + PW'(1);
      if (pre_tick) begin
        fac_q <= fac_wrap ? '0 : fac_q + FW'(1);
      end
    end
  end

  // R3: a zero factor ticks on every prescaler wrap
  p_zero_factor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (factor == '0 && pre_tick && !clr) |-> tick);

  // R2: the second stage only moves on a prescaler wrap
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pre_tick) |=> $stable(fac_q));
endmodule

// File: rtl/rail_mode_fsm.sv
module rail_mode_fsm
  import rail_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_fault,
  input  logic       cfg_state,
  input  logic       self_test,
  input  logic       label_mode,
  input  logic       fault_code_hi,
  output rail_mode_e mode_q,
  output logic       lbl_q,
  output logic       hi_q
);
  rail_mode_e mode_d;

  always_comb begin
    if (self_test)                mode_d = RM_OFF;
    else if (in_fault)            mode_d = RM_FAULT;
    else if (mode_q == RM_FAULT)  mode_d = RM_RUN;   // fault leaves only to normal
    else if (cfg_state)           mode_d = RM_CFG;
    else                          mode_d = RM_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_OFF;
      lbl_q  <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lbl_q  <= label_mode;
      if (mode_d == RM_FAULT && mode_q != RM_FAULT) hi_q <= fault_code_hi;
    end
  end

  // R10: never straight from fault to configuration
  p_no_fault_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_FAULT) |=> (mode_q != RM_CFG));

  // R11: fault wins over a configuration request
  p_fault_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fault && !self_test) |=> (mode_q == RM_FAULT));
endmodule

// File: rtl/rail_pin_enc.sv
module rail_pin_enc
  import rail_pkg::*;
#(
  parameter int unsigned NP = RAIL_PINS
) (
  input  rail_mode_e    mode,
  input  logic          phase,
  input  logic          lbl,
  input  logic          hi,
  output logic [NP-1:0] val,
  output logic [NP-1:0] oe
);
  for (genvar i = 0; i < NP; i++) begin : g_pin
    // phase 0: top pin high, others low; phase 1: inverted
    localparam logic HOME = (i == NP - 1);
    always_comb begin
      unique case (mode)
        RM_RUN:   begin val[i] = HOME ^ phase; oe[i] = 1'b1; end
        RM_CFG:   begin val[i] = HOME ^ phase; oe[i] = !lbl; end
        RM_FAULT: begin val[i] = hi;           oe[i] = 1'b1; end
        default:  begin val[i] = 1'b0;         oe[i] = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/dual_rail_fault_out.sv
module dual_rail_fault_out
  import rail_pkg::*;
#(
  parameter int unsigned PRE_DIV = 1024,
  parameter int unsigned FACT_W  = 8
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              in_fault,
  input  logic              cfg_state,
  input  logic              self_test,
  input  logic              label_mode,
  input  logic              fault_code_hi,
  input  logic [FACT_W-1:0] div_factor,
  output logic [1:0]        rail_val,
  output logic [1:0]        rail_oe
);
  rail_mode_e mode;
  logic       lbl, hi, tick, phase_q, clr;

  rail_mode_fsm u_fsm (
    .clk           (clk_osc),
    .rst_n         (rst_n),
    .in_fault      (in_fault),
    .cfg_state     (cfg_state),
    .self_test     (self_test),
    .label_mode    (label_mode),
    .fault_code_hi (fault_code_hi),
    .mode_q        (mode),
    .lbl_q         (lbl),
    .hi_q          (hi)
  );

  // dividers and phase restart while the pair is not alternating
  assign clr = (mode == RM_OFF) || (mode == RM_FAULT);

  rail_prescale #(.PRE_DIV(PRE_DIV), .FW(FACT_W)) u_div (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .clr    (clr),
    .factor (div_factor),
    .tick   (tick)
  );

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)      phase_q <= 1'b0;
    else if (clr)    phase_q <= 1'b0;
    else if (tick)   phase_q <= !phase_q;
  end

  rail_pin_enc #(.NP(2)) u_enc (
    .mode  (mode),
    .phase (phase_q),
    .lbl   (lbl),
    .hi    (hi),
    .val   (rail_val),
    .oe    (rail_oe)
  );

  // R1: a driven healthy pair is complementary
  p_complement_r1: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode == RM_RUN) |-> (rail_val[0] != rail_val[1]));

  // R4: fault code does not move during a fault
  p_fault_static_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode == RM_FAULT) |=> (mode != RM_FAULT) || $stable(rail_val));

  // R5: leaving a fault restarts at 10
  p_restart_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode == RM_FAULT && !in_fault && !self_test) |=> (rail_val == 2'b10 && rail_oe == 2'b11));

  // R7: self-test floats both pins
  p_selftest_off_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    self_test |=> (rail_oe == 2'b00));
endmodule

// File: tb/test_dual_rail_fault_out.sv
`timescale 1ns/1ps
module test_dual_rail_fault_out;
  localparam int unsigned PRE = 16;
  localparam int unsigned FW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_fault = 1'b0, cfg_state = 1'b0, self_test = 1'b0;
  logic          label_mode = 1'b0, fault_code_hi = 1'b0;
  logic [FW-1:0] div_factor = 8'd1;
  logic [1:0]    rail_val, rail_oe;

  always #2.5 clk = ~clk;

  dual_rail_fault_out #(.PRE_DIV(PRE), .FACT_W(FW)) i_dual_rail_fault_out (
    .clk_osc(clk), .rst_n(rst_n), .in_fault(in_fault), .cfg_state(cfg_state),
    .self_test(self_test), .label_mode(label_mode), .fault_code_hi(fault_code_hi),
    .div_factor(div_factor), .rail_val(rail_val), .rail_oe(rail_oe)
  );

  typedef struct {
    logic [1:0] v;
    logic [1:0] oe;
    logic [1:0] mask;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // toggle model from R1/R2/R3
  int ph = 0, ph_cnt = 0, half = PRE;

  // monitor: compare one item per edge, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (((rail_val & e.mask) !== (e.v & e.mask)) || (rail_oe !== e.oe)) begin
        bad++;
        $display("FAIL %s: val=%b oe=%b expected val=%b oe=%b (mask %b)",
                 e.tag, rail_val, rail_oe, e.v, e.oe, e.mask);
      end
    end
  end

  task automatic push_cyc(input logic [1:0] v, input logic [1:0] oe,
                          input logic [1:0] mask, input string tag);
    exp_t e;
    @(posedge clk);
    e.v = v; e.oe = oe; e.mask = mask; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic restart(input int f);
    ph = 0; ph_cnt = 0;
    half = PRE * ((f == 0) ? 1 : f);
  endtask

  task automatic advance();
    ph_cnt++;
    if (ph_cnt == half) begin ph_cnt = 0; ph ^= 1; end
  endtask

  task automatic run_toggle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      push_cyc(ph ? 2'b01 : 2'b10, 2'b11, 2'b11, tag);
      advance();
    end
  endtask

  task automatic run_hidden(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      push_cyc(2'b00, 2'b00, 2'b00, tag);
      advance();
    end
  endtask

  task automatic run_static(input int n, input logic [1:0] v, input logic [1:0] oe,
                            input logic [1:0] mask, input string tag);
    for (int i = 0; i < n; i++) push_cyc(v, oe, mask, tag);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: val=%b oe=%b expected run to complete", rail_val, rail_oe);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R6: reset floats the pins
    run_static(3, 2'b00, 2'b00, 2'b00, "R6 reset");
    rst_n = 1'b1;
    restart(1);
    run_toggle(40, "R1/R2 healthy f=1");

    // R4: fault code 00, held while fault_code_hi changes
    in_fault = 1'b1; fault_code_hi = 1'b0;
    run_static(4, 2'b00, 2'b11, 2'b11, "R4 fault 00");
    fault_code_hi = 1'b1;
    run_static(4, 2'b00, 2'b11, 2'b11, "R4 code held");

    // R5/R2: exit with factor 2
    div_factor = 8'd2; in_fault = 1'b0;
    restart(2);
    run_toggle(70, "R5/R2 restart f=2");

    // R4: fault code 11; then R3 factor zero
    in_fault = 1'b1; fault_code_hi = 1'b1;
    run_static(4, 2'b11, 2'b11, 2'b11, "R4 fault 11");
    div_factor = 8'd0; in_fault = 1'b0;
    restart(0);
    run_toggle(21, "R3 zero factor");

    // R8: transparency keeps toggling, no restart
    cfg_state = 1'b1; label_mode = 1'b0;
    run_toggle(20, "R8 transparent cfg");
    cfg_state = 1'b0;
    run_toggle(5, "R8 after cfg");

    // R9: labelling floats pins, phase keeps running
    cfg_state = 1'b1; label_mode = 1'b1;
    run_hidden(11, "R9 label cfg");
    cfg_state = 1'b0;
    run_toggle(20, "R9 resume phase");

    // R11: fault during configuration; R10: exit passes through normal
    cfg_state = 1'b1;
    run_hidden(3, "R9 label cfg");
    in_fault = 1'b1; fault_code_hi = 1'b0;
    run_static(3, 2'b00, 2'b11, 2'b11, "R11 fault over cfg");
    in_fault = 1'b0;
    restart(0);
    run_toggle(1, "R10 one normal cycle");
    run_hidden(5, "R10 then cfg");
    cfg_state = 1'b0; label_mode = 1'b0;
    run_toggle(10, "R10 after cfg");

    // R7: self-test beats fault, restart afterwards
    self_test = 1'b1; in_fault = 1'b1;
    run_static(4, 2'b00, 2'b00, 2'b00, "R7 self-test");
    self_test = 1'b0; in_fault = 1'b0;
    restart(0);
    run_toggle(20, "R7 after self-test");

    // R6: asynchronous reset mid-run
    rst_n = 1'b0;
    #0.5;
    total++;
    if (rail_oe !== 2'b00) begin
      bad++;
      $display("FAIL R6 async: oe=%b expected oe=00", rail_oe);
    end
    run_static(2, 2'b00, 2'b00, 2'b00, "R6 reset mid-run");
    rst_n = 1'b1;
    restart(0);
    run_toggle(18, "R1 after reset");

    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule